// File: doc/BRIEF.md
# Free-running 64-bit timer with periodic comparator

This block is a memory-mapped timer built around a 64-bit up-counter. Software reads and writes the counter through two 32-bit halves. A single 64-bit comparator raises a pending interrupt when the counter equals the programmed compare value. In periodic mode, each match reloads the compare value by adding a 32-bit increment to it, so interrupts arrive at a fixed spacing without software involvement.

Writes to the counter halves, the compare halves, the increment and the control register pass through a fixed apply delay. This models a crossing into the timer's own clock domain. When a write takes effect, a sticky per-register flag is raised. Software polls that flag to learn that the write has landed, then clears it by writing a one to it.

The register bus has no back-pressure. A write is accepted in every cycle in which `wr_en_i` is high, and there is no ready signal. Reads are combinational from `rd_addr_i`. A single level-sensitive interrupt line leaves the block.

Top module: `gct_timer_top`

## Requirements
- R1: After reset the counter, compare value, increment, control, interrupt enable, interrupt status and all write-status flags read as zero, and `irq_o` is low.
- R2: The counter advances by exactly one on each clock edge while the run bit (control 0x240, bit 8) is set, and holds its value while that bit is clear.
- R3: The counter low half is at 0x100 and the high half at 0x104. A write to one half replaces only that half and leaves the other half unchanged.
- R4: A write to 0x100, 0x104, 0x200, 0x204, 0x208 or 0x240 takes effect on the third clock edge after the edge that captured it. Until then, reads return the old value.
- R5: Each delayed write raises a sticky flag on the edge where it takes effect. The flags are at 0x110 bit 0 (counter low) and bit 1 (counter high), and at 0x24C bit 0 (compare low), bit 1 (compare high), bit 2 (increment) and bit 16 (control). Writing a one to a flag clears it on the next edge, writing a zero leaves it alone, and a set in the same edge wins over a clear.
- R6: When the comparator enable (0x240 bit 0) is set and the counter equals the compare value (0x200 low, 0x204 high), interrupt status bit 0 at 0x244 is set on the next edge.
- R7: With auto-increment (0x240 bit 1) set, every match adds the increment register (0x208) to the compare value. While the counter runs, matches then recur every increment cycles.
- R8: With auto-increment clear, a match leaves the compare value unchanged. After the status is cleared, no further interrupt follows while the counter moves on.
- R9: `irq_o` is high exactly when interrupt status bit 0 and interrupt enable bit 0 (0x248) are both set. Writes to 0x248 and the clear-by-one of 0x244 take effect on the next edge, without the apply delay.
- R10: With the comparator enable clear, equality of the counter and compare value sets no status.
- R11: Both halves read in the same cycle form one consistent value. Reading the high half, then the low half, then the high half again in later cycles shows a carry that happened between the reads as a changed high half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe, always accepted |
| wr_addr_i | input | 12 | Write byte offset |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 12 | Read byte offset |
| rd_data_o | output | 32 | Combinational read data, zero for unmapped offsets |
| irq_o | output | 1 | Comparator interrupt, level |

## Verification
The assertions check the following on every cycle:
- single-step counting, and holding while stopped;
- the auto-advance of the compare value on a match, and its stability without auto-increment;
- status setting one edge after a match;
- the control write flag rising on its apply edge;
- the one-edge clear of the pending status.

The bench scenarios cover what those properties cannot see:
- the exact three-edge apply latency observed from the bus;
- half-word isolation of counter writes;
- carry detection through a high-low-high read sequence;
- the measured spacing between periodic interrupts for random increments;
- the enable gating of `irq_o`;
- partial write-one-to-clear of the write-status flags.

// File: rtl/gct_pkg.sv
package gct_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 12;

  localparam logic [AW-1:0] OFS_CNT_LO  = 12'h100;
  localparam logic [AW-1:0] OFS_CNT_HI  = 12'h104;
  localparam logic [AW-1:0] OFS_CNT_WS  = 12'h110;
  localparam logic [AW-1:0] OFS_CMP_LO  = 12'h200;
  localparam logic [AW-1:0] OFS_CMP_HI  = 12'h204;
  localparam logic [AW-1:0] OFS_STEP    = 12'h208;
  localparam logic [AW-1:0] OFS_CTRL    = 12'h240;
  localparam logic [AW-1:0] OFS_IRQ_ST  = 12'h244;
  localparam logic [AW-1:0] OFS_IRQ_EN  = 12'h248;
  localparam logic [AW-1:0] OFS_WS      = 12'h24C;

  localparam int unsigned CTRL_RUN_BIT  = 8;
  localparam int unsigned CTRL_AUTO_BIT = 1;
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned WS_CTRL_BIT   = 16;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_CNT_LO, TGT_CNT_HI, TGT_CMP_LO, TGT_CMP_HI, TGT_STEP, TGT_CTRL
  } tgt_e;

  typedef struct packed {
    tgt_e          tgt;
    logic [DW-1:0] data;
  } pend_wr_t;
endpackage

// File: rtl/gct_apply_pipe.sv
module gct_apply_pipe
  import gct_pkg::*;
#(
  parameter int unsigned LAT = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pend_wr_t in_i,
  output pend_wr_t out_o
);
  pend_wr_t stage_q [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        stage_q[g] <= '{tgt: TGT_NONE, data: '0};
      end else if (g == 0) begin
        stage_q[g] <= in_i;
      end else begin
        stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign out_o = stage_q[LAT-1];
endmodule

// File: rtl/gct_counter.sv
module gct_counter
  import gct_pkg::*;
#(
  parameter int unsigned CW = 2*DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          ld_lo_i,
  input  logic          ld_hi_i,
  input  logic [DW-1:0] ld_data_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (ld_lo_i) begin
      cnt_q[DW-1:0] <= ld_data_i;
    end else if (ld_hi_i) begin
      cnt_q[CW-1:DW] <= ld_data_i;
    end else if (run_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ld_lo_i && !ld_hi_i) |=> $stable(cnt_q)) else $error("counter moved while stopped"); // R2
  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !ld_lo_i && !ld_hi_i) |=> (cnt_q == $past(cnt_q) + 1'b1)) else $error("counter step not one"); // R2
endmodule

// File: rtl/gct_compare.sv
module gct_compare
  import gct_pkg::*;
#(
  parameter int unsigned CW = 2*DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic          en_i,
  input  logic          auto_i,
  input  logic          ld_lo_i,
  input  logic          ld_hi_i,
  input  logic          ld_step_i,
  input  logic [DW-1:0] ld_data_i,
  output logic [CW-1:0] cmp_o,
  output logic [DW-1:0] step_o,
  output logic          match_o
);
  logic [CW-1:0] cmp_q;
  logic [DW-1:0] step_q;
  logic          hit;

  assign hit = en_i && (cnt_i == cmp_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cmp_q <= '0;
    end else if (ld_lo_i) begin
      cmp_q[DW-1:0] <= ld_data_i;
    end else if (ld_hi_i) begin
      cmp_q[CW-1:DW] <= ld_data_i;
    end else if (hit && auto_i) begin
      cmp_q <= cmp_q + {{(CW-DW){1'b0}}, step_q};
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) step_q <= '0;
    else if (ld_step_i) step_q <= ld_data_i;
  end

  assign cmp_o   = cmp_q;
  assign step_o  = step_q;
  assign match_o = hit;

  AST_AUTO_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && auto_i && !ld_lo_i && !ld_hi_i) |=>
      (cmp_q == $past(cmp_q) + {{(CW-DW){1'b0}}, $past(step_q)})) else $error("compare did not advance"); // R7
  AST_ONESHOT_KEEPS_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !auto_i && !ld_lo_i && !ld_hi_i) |=> $stable(cmp_q)) else $error("compare moved in one-shot"); // R8
endmodule

// File: rtl/gct_timer_top.sv
module gct_timer_top
  import gct_pkg::*;
#(
  parameter int unsigned APPLY_LAT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_o
);
  localparam int unsigned CW = 2*DW;

  pend_wr_t      wr_in, wr_app;
  logic          run_q, auto_q, en_q, irq_en_q, stat_q;
  logic [1:0]    ws_cnt_q;
  logic [2:0]    ws_cmp_q;
  logic          ws_ctrl_q;
  logic [CW-1:0] cnt, cmp;
  logic [DW-1:0] step;
  logic          match;
  logic          wr_stat_clr, wr_cws, wr_gws;

  always_comb begin
    wr_in.data = wr_data_i;
    wr_in.tgt  = TGT_NONE;
    if (wr_en_i) begin
      unique case (wr_addr_i)
        OFS_CNT_LO: wr_in.tgt = TGT_CNT_LO;
        OFS_CNT_HI: wr_in.tgt = TGT_CNT_HI;
        OFS_CMP_LO: wr_in.tgt = TGT_CMP_LO;
        OFS_CMP_HI: wr_in.tgt = TGT_CMP_HI;
        OFS_STEP:   wr_in.tgt = TGT_STEP;
        OFS_CTRL:   wr_in.tgt = TGT_CTRL;
        default:    wr_in.tgt = TGT_NONE;
      endcase
    end
  end

  gct_apply_pipe #(.LAT(APPLY_LAT)) u_pipe (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(wr_in), .out_o(wr_app)
  );

  gct_counter #(.CW(CW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q),
    .ld_lo_i(wr_app.tgt == TGT_CNT_LO), .ld_hi_i(wr_app.tgt == TGT_CNT_HI),
    .ld_data_i(wr_app.data), .cnt_o(cnt)
  );

  gct_compare #(.CW(CW)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .en_i(en_q), .auto_i(auto_q),
    .ld_lo_i(wr_app.tgt == TGT_CMP_LO), .ld_hi_i(wr_app.tgt == TGT_CMP_HI),
    .ld_step_i(wr_app.tgt == TGT_STEP), .ld_data_i(wr_app.data),
    .cmp_o(cmp), .step_o(step), .match_o(match)
  );

  assign wr_stat_clr = wr_en_i && (wr_addr_i == OFS_IRQ_ST) && wr_data_i[0];
  assign wr_cws      = wr_en_i && (wr_addr_i == OFS_CNT_WS);
  assign wr_gws      = wr_en_i && (wr_addr_i == OFS_WS);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      {run_q, auto_q, en_q} <= '0;
      irq_en_q  <= 1'b0;
      stat_q    <= 1'b0;
      ws_cnt_q  <= '0;
      ws_cmp_q  <= '0;
      ws_ctrl_q <= 1'b0;
    end else begin
      if (wr_app.tgt == TGT_CTRL) begin
        run_q  <= wr_app.data[CTRL_RUN_BIT];
        auto_q <= wr_app.data[CTRL_AUTO_BIT];
        en_q   <= wr_app.data[CTRL_EN_BIT];
      end
      if (wr_en_i && (wr_addr_i == OFS_IRQ_EN)) irq_en_q <= wr_data_i[0];
      if (match) stat_q <= 1'b1;
      else if (wr_stat_clr) stat_q <= 1'b0;
      ws_cnt_q <= (ws_cnt_q & ~({2{wr_cws}} & wr_data_i[1:0]))
                | {wr_app.tgt == TGT_CNT_HI, wr_app.tgt == TGT_CNT_LO};
      ws_cmp_q <= (ws_cmp_q & ~({3{wr_gws}} & wr_data_i[2:0]))
                | {wr_app.tgt == TGT_STEP, wr_app.tgt == TGT_CMP_HI, wr_app.tgt == TGT_CMP_LO};
      ws_ctrl_q <= (ws_ctrl_q & ~(wr_gws & wr_data_i[WS_CTRL_BIT])) | (wr_app.tgt == TGT_CTRL);
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      OFS_CNT_LO: rd_data_o = cnt[DW-1:0];
      OFS_CNT_HI: rd_data_o = cnt[CW-1:DW];
      OFS_CNT_WS: rd_data_o[1:0] = ws_cnt_q;
      OFS_CMP_LO: rd_data_o = cmp[DW-1:0];
      OFS_CMP_HI: rd_data_o = cmp[CW-1:DW];
      OFS_STEP:   rd_data_o = step;
      OFS_CTRL: begin
        rd_data_o[CTRL_RUN_BIT]  = run_q;
        rd_data_o[CTRL_AUTO_BIT] = auto_q;
        rd_data_o[CTRL_EN_BIT]   = en_q;
      end
      OFS_IRQ_ST: rd_data_o[0] = stat_q;
      OFS_IRQ_EN: rd_data_o[0] = irq_en_q;
      OFS_WS: begin
        rd_data_o[2:0]         = ws_cmp_q;
        rd_data_o[WS_CTRL_BIT] = ws_ctrl_q;
      end
      default: rd_data_o = '0;
    endcase
  end

  assign irq_o = stat_q & irq_en_q;

  AST_STATUS_AFTER_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> stat_q) else $error("match did not raise status"); // R6
  AST_CTRL_FLAG_ON_APPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_app.tgt == TGT_CTRL) |=> ws_ctrl_q) else $error("control flag missing"); // R5
  AST_STATUS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat_clr && !match) |=> !stat_q) else $error("status clear lost"); // R9
endmodule

// File: tb/gct_timer_top_tb_top.sv
module gct_timer_top_tb_top;
  import gct_pkg::*;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          irq;
  int            n_chk = 0;
  int            n_err = 0;
  int            cyc = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gct_timer_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic rd64(output logic [63:0] v);
    logic [DW-1:0] lo, hi;
    bus_rd(OFS_CNT_LO, lo);
    bus_rd(OFS_CNT_HI, hi);
    v = {hi, lo};
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] add64(input logic [63:0] a, input int k);
    return a + 64'(k);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [63:0]   v, v1;
    logic [DW-1:0] d, hi1, hi2;
    int            seed;
    seed = $urandom(32'd2024);
    wait_n(4);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd64(v); chk("R1 counter", v, 0);
    bus_rd(OFS_CTRL, d); chk("R1 ctrl", d, 0);
    bus_rd(OFS_IRQ_ST, d); chk("R1 status", d, 0);
    bus_rd(OFS_WS, d); chk("R1 wstat", d, 0);
    bus_rd(OFS_CMP_LO, d); chk("R1 cmp", d, 0);
    chk("R1 irq", irq, 0);
    wait_n(5); rd64(v); chk("R2 stopped hold", v, 0);

    // R4 apply latency and R5 flags
    bus_wr(OFS_CNT_LO, 32'h1234_5678);
    bus_rd(OFS_CNT_LO, d); chk("R4 old after T", d, 0);
    bus_rd(OFS_CNT_WS, d); chk("R5 no flag yet", d, 0);
    wait_n(1); bus_rd(OFS_CNT_LO, d); chk("R4 old after T+1", d, 0);
    wait_n(1); bus_rd(OFS_CNT_LO, d); chk("R4 old after T+2", d, 0);
    wait_n(1); bus_rd(OFS_CNT_LO, d); chk("R4 applied T+3", d, 32'h1234_5678);
    bus_rd(OFS_CNT_WS, d); chk("R5 lo flag", d, 1);
    bus_wr(OFS_CNT_HI, 32'hA); wait_n(3);
    rd64(v); chk("R3 hi only", v, 64'hA_1234_5678);
    bus_rd(OFS_CNT_WS, d); chk("R5 both flags", d, 3);
    bus_wr(OFS_CNT_WS, 1); bus_rd(OFS_CNT_WS, d); chk("R5 w1c bit0", d, 2);
    bus_wr(OFS_CNT_WS, 0); bus_rd(OFS_CNT_WS, d); chk("R5 write zero keeps", d, 2);
    bus_wr(OFS_CNT_WS, 2); bus_rd(OFS_CNT_WS, d); chk("R5 w1c bit1", d, 0);

    // R2 counting
    rd64(v);
    bus_wr(OFS_CTRL, 32'h100);
    wait_n(3); rd64(v1); chk("R2 held until apply", v1, v);
    bus_rd(OFS_WS, d); chk("R5 ctrl flag", d, 32'h1_0000);
    wait_n(10); rd64(v1); chk("R2 ten steps", v1, add64(v, 10));
    bus_wr(OFS_CTRL, 0); rd64(v);
    wait_n(3); rd64(v1); chk("R2 stop after apply", v1, add64(v, 3));
    wait_n(5); rd64(v1); chk("R2 hold stopped", v1, add64(v, 3));

    // R11 carry between reads
    bus_wr(OFS_CNT_LO, 32'hFFFF_FFFC); wait_n(3);
    bus_wr(OFS_CNT_HI, 32'h7); wait_n(3);
    bus_wr(OFS_CTRL, 32'h100); wait_n(3);
    rd64(v); chk("R11 start", v, 64'h7_FFFF_FFFC);
    bus_rd(OFS_CNT_HI, hi1);
    wait_n(4); rd64(v); chk("R11 carry same cycle", v, 64'h8_0000_0000);
    wait_n(1); bus_rd(OFS_CNT_HI, hi2);
    chk("R11 reread hi", hi2, 8); chk("R11 hi changed", hi1 != hi2, 1);
    bus_wr(OFS_CTRL, 0); wait_n(3);

    // R6 R8 one-shot
    bus_wr(OFS_CNT_LO, 100); wait_n(3);
    bus_wr(OFS_CNT_HI, 0); wait_n(3);
    bus_wr(OFS_CMP_LO, 120); wait_n(3);
    bus_wr(OFS_IRQ_EN, 1);
    bus_wr(OFS_CTRL, 32'h101);
    wait_n(23); chk("R6 no irq before match", irq, 0);
    wait_n(1); chk("R6 irq after match", irq, 1);
    bus_rd(OFS_IRQ_ST, d); chk("R6 status", d, 1);
    bus_rd(OFS_CMP_LO, d); chk("R8 cmp unchanged", d, 120);
    bus_wr(OFS_IRQ_ST, 1); chk("R9 clear", irq, 0);
    wait_n(60); chk("R8 no repeat", irq, 0);

    // R10, R9 gating
    bus_wr(OFS_CTRL, 0); wait_n(3);
    bus_wr(OFS_CNT_LO, 120); wait_n(3);
    bus_wr(OFS_CNT_HI, 0); wait_n(3);
    bus_wr(OFS_IRQ_ST, 1);
    wait_n(5); bus_rd(OFS_IRQ_ST, d); chk("R10 disabled no status", d, 0);
    bus_wr(OFS_IRQ_EN, 0);
    bus_wr(OFS_CTRL, 32'h001); wait_n(4);
    bus_rd(OFS_IRQ_ST, d); chk("R9 status set", d, 1);
    chk("R9 irq masked", irq, 0);
    bus_wr(OFS_IRQ_EN, 1); chk("R9 irq unmasked", irq, 1);
    bus_wr(OFS_CTRL, 0); wait_n(3);
    bus_wr(OFS_IRQ_ST, 1); chk("R9 cleared", irq, 0);

    // R7 periodic with random increments
    for (int t = 0; t < 4; t++) begin
      int step, t0, k;
      step = $urandom_range(40, 8);
      bus_wr(OFS_CTRL, 0); wait_n(3);
      bus_wr(OFS_IRQ_ST, 1);
      bus_wr(OFS_CNT_LO, 0); wait_n(3);
      bus_wr(OFS_CMP_LO, 50); wait_n(3);
      bus_wr(OFS_STEP, step); wait_n(3);
      bus_wr(OFS_CTRL, 32'h103);
      k = 0; while (!irq && k < 200) begin wait_n(1); k++; end
      for (int g = 0; g < 3; g++) begin
        t0 = cyc;
        bus_wr(OFS_IRQ_ST, 1);
        k = 0; while (!irq && k < 200) begin wait_n(1); k++; end
        chk("R7 period", cyc - t0, step);
      end
    end
    bus_wr(OFS_CTRL, 0); wait_n(3);

    // R3 random half writes
    for (int i = 0; i < 8; i++) begin
      logic [DW-1:0] lo, hi;
      lo = $urandom(); hi = $urandom();
      bus_wr(OFS_CNT_LO, lo); wait_n(3);
      bus_wr(OFS_CNT_HI, hi); wait_n(3);
      rd64(v); chk("R3 random readback", v, {hi, lo});
      bus_wr(OFS_CNT_LO, ~lo); wait_n(3);
      rd64(v); chk("R3 lo keeps hi", v, {hi, ~lo});
    end

    // R5 random partial clears
    for (int i = 0; i < 6; i++) begin
      logic [DW-1:0] m, exp;
      bus_wr(OFS_WS, 32'h1_0007);
      bus_wr(OFS_CMP_LO, 7); bus_wr(OFS_CMP_HI, 0); bus_wr(OFS_STEP, 9);
      wait_n(3);
      bus_rd(OFS_WS, d); chk("R5 cmp flags", d, 32'h7);
      m = $urandom() & 32'h1_0007;
      exp = 32'h7 & ~m;
      bus_wr(OFS_WS, m); bus_rd(OFS_WS, d); chk("R5 partial clear", d, exp);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule